// File: doc/BRIEF.md
# Transactional Conflict Tracker

This block sits next to a small first-level data cache and follows a core through a hardware memory transaction. The core sends begin, commit and abort commands on its normal load port, as loads that carry a nonzero command field. Between begin and the end of the transaction, the block records which cache lines the core has read and which it has written. It checks every coherence snoop from other agents against those records. A snoop that conflicts fails the transaction. The failure is sticky and keeps the reason code of the first conflict.

After a failure, each core load and store is turned into a no-op. The block does not forward it to the cache, does not record it, and answers it with a failure flag. The core then issues an abort. The abort discards the speculative lines with a one-cycle invalidate mask and returns the block to normal operation. A commit on a healthy transaction instead releases the written lines with a one-cycle publish mask. A commit on a failed transaction is treated as an abort.

Top module: `htm_conflict_tracker`

## Requirements
- R1: After synchronous reset, `tx_mode`, `tx_failed`, `fail_reason`, `inv_mask` and `pub_mask` are all zero.
- R2: Outside transactional mode, loads and stores are forwarded (`cache_en`=1, `rsp_fail`=0) and add no line to either set. A begin command enters transactional mode on the next cycle.
- R3: In transactional mode, with no failure, a load adds its line to the read set and a store adds its line to the write set.
- R4: An invalidation snoop (`snp_remote_read`=0) fails the transaction when its line is in the write set (reason 2'b10) or only in the read set (reason 2'b01). The write-set reason wins when the line is in both sets. A snoop to an untracked line, or any snoop outside transactional mode, has no effect.
- R5: A remote-read snoop (`snp_remote_read`=1) to a write-set line fails the transaction with reason 2'b11. A remote read of a line that is only in the read set has no effect.
- R6: While the transaction is failed, every core load and store gives `cache_en`=0 and `rsp_fail`=1, and adds no line to either set.
- R7: The failure is sticky. A later conflict does not change `fail_reason` until the transaction ends.
- R8: Abort drives `inv_mask` equal to the write set for exactly that cycle. On the next cycle, failure, reason, both sets and transactional mode are all cleared.
- R9: Commit of a transaction that has not failed drives `pub_mask` equal to the write set for exactly that cycle (`inv_mask` zero), then clears both sets and leaves transactional mode.
- R10: Commands are loads (`req_store`=0) whose `req_cmd` field is 2'b01 begin, 2'b10 commit or 2'b11 abort; 2'b00 marks an ordinary access. A begin received while already in transactional mode has no effect.
- R11: When a snoop and a core access arrive in the same cycle, the snoop is evaluated first. If the snoop conflicts, the access is already a no-op with `rsp_fail`=1.
- R12: A commit received while the transaction is failed (including a failure caused by a snoop in the same cycle) acts as an abort. It drives `inv_mask` with the write set, `pub_mask` zero, and `rsp_fail`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_store | input | 1 | 1 = store, 0 = load or command |
| req_cmd | input | 2 | Command field of a load: 00 none, 01 begin, 10 commit, 11 abort |
| req_line | input | IW | Cache line index of the access |
| snp_valid | input | 1 | Snoop from another agent present |
| snp_remote_read | input | 1 | 1 = remote read, 0 = invalidation |
| snp_line | input | IW | Cache line index of the snoop |
| cache_en | output | 1 | Access forwarded to the cache this cycle |
| rsp_valid | output | 1 | Response for the current request |
| rsp_fail | output | 1 | Response carries the transaction-failed flag |
| tx_mode | output | 1 | Transactional mode active |
| tx_failed | output | 1 | Sticky transaction failure |
| fail_reason | output | 2 | First failure cause: 01 inv of read line, 10 inv of written line, 11 remote read of written line |
| inv_mask | output | LINES | One-cycle per-line invalidate strobes on abort |
| pub_mask | output | LINES | One-cycle per-line publish strobes on commit |

## Verification
The bench targets a line that is both read and written, then invalidated. A design that checks the read set first would report 01 instead of 10. A remote read of a line that was only read must leave the transaction healthy; a design that treats remote reads like invalidations would fail it. Stores made after a failure must not appear in the abort invalidate mask, and a snoop that arrives in the same cycle as an access must turn that access into a no-op. A commit on a failed transaction must give invalidate strobes and no publish strobes. A design that ignores the failure there would leak speculative lines. The bench also checks that the strobes last exactly one cycle.

// File: rtl/htm_trk_pkg.sv
package htm_trk_pkg;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'b00,
        CMD_BEGIN  = 2'b01,
        CMD_COMMIT = 2'b10,
        CMD_ABORT  = 2'b11
    } htm_cmd_e;

    typedef enum logic [1:0] {
        RSN_NONE     = 2'b00,
        RSN_INV_RD   = 2'b01,
        RSN_INV_WR   = 2'b10,
        RSN_RREAD_WR = 2'b11
    } fail_rsn_e;

    typedef struct packed {
        logic      hit;
        fail_rsn_e rsn;
    } conflict_t;

    function automatic logic cmd_ends_tx(htm_cmd_e c);
        return (c == CMD_COMMIT) || (c == CMD_ABORT);
    endfunction

endpackage

// File: rtl/htm_set_array.sv
module htm_set_array #(
    parameter int LINES = 8,
    localparam int IW = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             set_rd,
    input  logic             set_wr,
    input  logic [IW-1:0]    line,
    output logic [LINES-1:0] rd_set,
    output logic [LINES-1:0] wr_set
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic hit_line;
        assign hit_line = (line == IW'(i));

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                rd_set[i] <= 1'b0;
                wr_set[i] <= 1'b0;
            end else begin
                if (set_rd && hit_line) rd_set[i] <= 1'b1;
                if (set_wr && hit_line) wr_set[i] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/htm_conflict.sv
module htm_conflict
    import htm_trk_pkg::*;
#(
    parameter int LINES = 8,
    localparam int IW = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             active,
    input  logic             snp_valid,
    input  logic             snp_remote_read,
    input  logic [IW-1:0]    snp_line,
    input  logic [LINES-1:0] rd_set,
    input  logic [LINES-1:0] wr_set,
    output conflict_t        cf
);
    logic in_rd, in_wr;

    always_comb begin
        in_rd = 1'b0;
        in_wr = 1'b0;
        for (int i = 0; i < LINES; i++) begin
            if (snp_line == IW'(i)) begin
                in_rd = rd_set[i];
                in_wr = wr_set[i];
            end
        end
    end

    always_comb begin
        cf = '{hit: 1'b0, rsn: RSN_NONE};
        if (active && snp_valid) begin
            if (snp_remote_read) begin
                if (in_wr) cf = '{hit: 1'b1, rsn: RSN_RREAD_WR};
            end else if (in_wr) begin
                cf = '{hit: 1'b1, rsn: RSN_INV_WR};
            end else if (in_rd) begin
                cf = '{hit: 1'b1, rsn: RSN_INV_RD};
            end
        end
    end
endmodule

// File: rtl/htm_fail_state.sv
module htm_fail_state
    import htm_trk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      begin_tx,
    input  logic      end_tx,
    input  conflict_t cf,
    output logic      active,
    output logic      failed,
    output fail_rsn_e rsn
);
    always_ff @(posedge clk) begin
        if (rst || end_tx) begin
            active <= 1'b0;
            failed <= 1'b0;
            rsn    <= RSN_NONE;
        end else if (begin_tx) begin
            active <= 1'b1;
            failed <= 1'b0;
            rsn    <= RSN_NONE;
        end else if (cf.hit && !failed) begin
            failed <= 1'b1;
            rsn    <= cf.rsn;
        end
    end

    // R7
    sticky_reason_chk: assert property (@(posedge clk) disable iff (rst)
        (failed && !end_tx && !begin_tx) |=> (failed && $stable(rsn)));
endmodule

// File: rtl/htm_conflict_tracker.sv
module htm_conflict_tracker
    import htm_trk_pkg::*;
#(
    parameter int LINES = 8,
    localparam int IW = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_store,
    input  logic [1:0]       req_cmd,
    input  logic [IW-1:0]    req_line,
    input  logic             snp_valid,
    input  logic             snp_remote_read,
    input  logic [IW-1:0]    snp_line,
    output logic             cache_en,
    output logic             rsp_valid,
    output logic             rsp_fail,
    output logic             tx_mode,
    output logic             tx_failed,
    output logic [1:0]       fail_reason,
    output logic [LINES-1:0] inv_mask,
    output logic [LINES-1:0] pub_mask
);
    htm_cmd_e         cmd;
    conflict_t        cf;
    fail_rsn_e        rsn;
    logic             active, failed;
    logic             is_cmd, acc, eff_fail;
    logic             do_begin, do_end, commit_ok;
    logic             set_rd, set_wr;
    logic [LINES-1:0] rd_set, wr_set;

    assign cmd       = htm_cmd_e'(req_cmd);
    assign is_cmd    = req_valid && !req_store && (cmd != CMD_NONE);
    assign acc       = req_valid && !is_cmd;
    // snoop result of this cycle counts before the core access
    assign eff_fail  = active && (failed || cf.hit);
    assign do_begin  = is_cmd && (cmd == CMD_BEGIN) && !active;
    assign do_end    = is_cmd && cmd_ends_tx(cmd);
    assign commit_ok = is_cmd && (cmd == CMD_COMMIT) && active && !eff_fail;
    assign set_rd    = acc && !req_store && active && !eff_fail;
    assign set_wr    = acc &&  req_store && active && !eff_fail;

    htm_set_array #(.LINES(LINES)) u_sets (
        .clk    (clk),
        .rst    (rst),
        .clr    (do_end),
        .set_rd (set_rd),
        .set_wr (set_wr),
        .line   (req_line),
        .rd_set (rd_set),
        .wr_set (wr_set)
    );

    htm_conflict #(.LINES(LINES)) u_conf (
        .active          (active),
        .snp_valid       (snp_valid),
        .snp_remote_read (snp_remote_read),
        .snp_line        (snp_line),
        .rd_set          (rd_set),
        .wr_set          (wr_set),
        .cf              (cf)
    );

    htm_fail_state u_fail (
        .clk      (clk),
        .rst      (rst),
        .begin_tx (do_begin),
        .end_tx   (do_end),
        .cf       (cf),
        .active   (active),
        .failed   (failed),
        .rsn      (rsn)
    );

    assign cache_en    = acc && !eff_fail;
    assign rsp_valid   = req_valid;
    assign rsp_fail    = req_valid && eff_fail;
    assign tx_mode     = active;
    assign tx_failed   = failed;
    assign fail_reason = rsn;
    assign pub_mask    = commit_ok ? wr_set : '0;
    assign inv_mask    = (do_end && !commit_ok) ? wr_set : '0;

    // R6
    failed_noop_chk: assert property (@(posedge clk) disable iff (rst)
        (active && failed && acc) |=> ($stable(rd_set) && $stable(wr_set)));

    // R8
    end_clears_chk: assert property (@(posedge clk) disable iff (rst)
        do_end |=> (!active && !failed && rd_set == '0 && wr_set == '0));

    // R9
    strobe_disjoint_chk: assert property (@(posedge clk) disable iff (rst)
        (inv_mask & pub_mask) == '0);

    // R4
    hit_reason_chk: assert property (@(posedge clk) disable iff (rst)
        cf.hit |-> (cf.rsn != RSN_NONE));

    // R2
    idle_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (!active && !do_begin) |=> (rd_set == '0 && wr_set == '0));
endmodule

// File: tb/htm_conflict_tracker_test.sv
module htm_conflict_tracker_test;
    localparam int CLK_PERIOD = 10;
    localparam int LINES = 8;
    localparam int IW = 3;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 0, req_store = 0, snp_valid = 0, snp_remote_read = 0;
    logic [1:0] req_cmd = 0;
    logic [IW-1:0] req_line = 0, snp_line = 0;
    logic cache_en, rsp_valid, rsp_fail, tx_mode, tx_failed;
    logic [1:0] fail_reason;
    logic [LINES-1:0] inv_mask, pub_mask;

    int checks = 0, errors = 0;
    logic c_en, c_fail;
    logic [LINES-1:0] c_inv, c_pub;

    always #(CLK_PERIOD/2) clk = ~clk;

    htm_conflict_tracker #(.LINES(LINES)) uut (.*);

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // apply one cycle of stimulus; capture combinational outputs before the edge
    task automatic cyc(logic rv, logic st, logic [1:0] cm, int rl,
                       logic sv, logic sk, int sl);
        @(negedge clk);
        req_valid = rv; req_store = st; req_cmd = cm; req_line = IW'(rl);
        snp_valid = sv; snp_remote_read = sk; snp_line = IW'(sl);
        #1;
        c_en = cache_en; c_fail = rsp_fail; c_inv = inv_mask; c_pub = pub_mask;
        @(posedge clk); #1;
        req_valid = 0; req_store = 0; req_cmd = 0; snp_valid = 0;
    endtask

    task automatic ld(int l);   cyc(1, 0, 2'b00, l, 0, 0, 0); endtask
    task automatic st(int l);   cyc(1, 1, 2'b00, l, 0, 0, 0); endtask
    task automatic cmd(logic [1:0] c); cyc(1, 0, c, 0, 0, 0, 0); endtask
    task automatic snp(logic k, int l); cyc(0, 0, 2'b00, 0, 1, k, l); endtask
    task automatic idle(); cyc(0, 0, 2'b00, 0, 0, 0, 0); endtask

    task automatic t_reset();
        chk("R1 tx_mode", tx_mode, 0);
        chk("R1 failed", tx_failed, 0);
        chk("R1 reason", fail_reason, 0);
        chk("R1 masks", {inv_mask, pub_mask}, 0);
    endtask

    task automatic t_passthru();
        st(3);
        chk("R2 fwd", c_en, 1);
        chk("R2 nofail", c_fail, 0);
        snp(0, 3);
        chk("R4 snoop outside mode", tx_failed, 0);
        cmd(2'b01);
        chk("R2 enter", tx_mode, 1);
        cmd(2'b10);
        chk("R2 no set outside", c_pub, 0);
        chk("R9 leave", tx_mode, 0);
    endtask

    task automatic t_commit();
        cmd(2'b01);
        st(2); chk("R3 store fwd", c_en, 1);
        st(5); ld(1);
        cmd(2'b01);
        chk("R10 begin ignored", {tx_mode, tx_failed}, 2'b10);
        cmd(2'b10);
        chk("R9 pub", c_pub, 8'b0010_0100);
        chk("R9 inv", c_inv, 0);
        chk("R9 rsp", c_fail, 0);
        chk("R9 exit", tx_mode, 0);
        idle();
        chk("R9 one cycle", c_pub, 0);
    endtask

    task automatic t_inv_rd();
        cmd(2'b01); ld(1);
        snp(0, 6);
        chk("R4 untracked", tx_failed, 0);
        snp(1, 1);
        chk("R5 rread of read line", tx_failed, 0);
        snp(0, 1);
        chk("R4 read-set fail", {tx_failed, fail_reason}, 3'b1_01);
        cmd(2'b11);
        chk("R8 inv empty", c_inv, 0);
        chk("R8 cleared", {tx_mode, tx_failed, fail_reason}, 0);
    endtask

    task automatic t_inv_wr();
        cmd(2'b01); ld(4); st(4);
        snp(0, 4);
        chk("R4 write precedence", fail_reason, 2'b10);
        cmd(2'b11);
        chk("R8 inv mask", c_inv, 8'b0001_0000);
        chk("R8 pub none", c_pub, 0);
    endtask

    task automatic t_rread();
        cmd(2'b01); ld(3); st(6);
        snp(1, 3);
        chk("R5 read-only ok", tx_failed, 0);
        snp(1, 6);
        chk("R5 rread write", {tx_failed, fail_reason}, 3'b1_11);
        snp(0, 3);
        chk("R7 sticky", fail_reason, 2'b11);
        st(0);
        chk("R6 store noop", {c_en, c_fail}, 2'b01);
        ld(7);
        chk("R6 load noop", {c_en, c_fail}, 2'b01);
        cmd(2'b11);
        chk("R6 R8 inv excludes late store", c_inv, 8'b0100_0000);
        cmd(2'b01); cmd(2'b10);
        chk("R8 sets cleared", c_pub, 0);
    endtask

    task automatic t_same_cycle();
        cmd(2'b01); st(2);
        cyc(1, 0, 2'b00, 5, 1, 0, 2);
        chk("R11 access noop", {c_en, c_fail}, 2'b01);
        chk("R11 reason", fail_reason, 2'b10);
        cmd(2'b11);
        chk("R11 load not tracked", c_inv, 8'b0000_0100);
    endtask

    task automatic t_commit_failed();
        cmd(2'b01); st(1); ld(2);
        snp(0, 2);
        chk("R4 fail 01", fail_reason, 2'b01);
        cmd(2'b10);
        chk("R12 pub none", c_pub, 0);
        chk("R12 inv", c_inv, 8'b0000_0010);
        chk("R12 rsp_fail", c_fail, 1);
        chk("R12 cleared", {tx_mode, tx_failed}, 0);
        cmd(2'b01); st(3);
        cyc(1, 0, 2'b10, 0, 1, 1, 3);
        chk("R12 same-cycle snoop commit", {c_pub, c_inv}, {8'h00, 8'b0000_1000});
        chk("R12 same-cycle rsp", c_fail, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_passthru();
        t_commit();
        t_inv_rd();
        t_inv_wr();
        t_rread();
        t_same_cycle();
        t_commit_failed();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule